// File: doc/BRIEF.md
# Power Button Pulse Stretcher

This block sits between a debounced, active-low power button and the active-low power button line of a host chipset. Many chipsets carry their own forced-reset timer that fires after roughly four seconds of a held button, which is too short for an orderly lock-and-logout sequence. The block reshapes a press while the host is running: a short low pulse wakes the host and raises its button interrupt, then the line is released for almost the whole forced-reset window, then it is pulled low again for the rest of the hold. The host's own timer therefore restarts late and fires only after about eight seconds of continuous holding.

When the host is off, a press becomes a stretched low pulse of fixed length, so that the host has time to wake even if the button is tapped. The block also makes forced wake pulses: one when the lid opens while the host is off, and one after reset once the power source reports that power-up is allowed. Button edges that arrive during a forced pulse are ignored, and a release that follows a forced pulse still held is swallowed. All timing is counted on a 1 ms tick input; the durations are parameters.

Top module: `pwrkey_stretch`

## Requirements
- R1: While reset is asserted and in the cycle after it, host_btn_n is high; the block leaves reset in the power-on wait state.
- R2: With the host on (host_off=0) and pulse mode enabled, a press (btn_n falling to 0) drives host_btn_n low from the next cycle for T0_MS ticks, high for HOLD_MS-T0_MS ticks, then low for as long as btn_n stays 0.
- R3: With pulse mode disabled and the host on, a press leaves host_btn_n high for HOLD_MS-T0_MS ticks and then drives it low while the button stays held.
- R4: If the host is off when the long gap ends, host_btn_n is not driven low again; the block still moves to its held state.
- R5: A release (btn_n rising to 1) during the short pulse, the gap or the held phase drives host_btn_n high on the next cycle, and no later re-assertion follows.
- R6: A press while the host is off drives host_btn_n low for STRETCH_MS ticks whatever the button does; at the end the line stays low if btn_n is still 0 and goes high otherwise.
- R7: A lid_open_evt pulse while the host is off, outside the power-on wait state, drives host_btn_n low for STRETCH_MS ticks and then high; with the host on it has no effect.
- R8: Button edges are ignored during the lid pulse, the stretched off-state pulse, the forced boot pulse and the power-on wait.
- R9: In the power-on wait the block samples pwr_ok on the first tick after reset and then every RECHECK_MS ticks, and issues a STRETCH_MS-tick low pulse once it reads 1; after INIT_TIMEOUT_MS ticks from reset it gives up and goes idle without pulsing.
- R10: If the button is still held when the forced boot pulse ends, its next release produces no edge on host_btn_n, and the press after that is handled normally.
- R11: While host_off=1 and pwr_ok=0, host_btn_n is held high even when the block requests low.
- R12: cfg_wr loads cfg_pulse_en into the pulse-mode setting (1 = enabled, the reset value); a host_evt pulse sets pulse mode enabled and wins over a simultaneous write.
- R13: Durations advance only on cycles with tick_ms=1; while tick_ms=0 the current phase does not end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe marking each millisecond |
| btn_n | input | 1 | Debounced button level, 0 = pressed |
| host_off | input | 1 | 1 while the host chipset is in any off state |
| pwr_ok | input | 1 | 1 when the power source allows the host to power up |
| lid_open_evt | input | 1 | One-cycle pulse when the lid opens |
| host_evt | input | 1 | One-cycle pulse on any host startup, shutdown, suspend or resume |
| cfg_wr | input | 1 | Write strobe for the pulse-mode setting |
| cfg_pulse_en | input | 1 | Pulse-mode value written by cfg_wr, 1 = short pulse enabled |
| host_btn_n | output | 1 | Power button line to the host, 0 = pressed |

## Verification
The main reshaping is tried with a press held through all three phases, a press released inside the short pulse, a press with pulse mode off and a press during which the host turns off in the gap; together these separate the pulse length, the gap length, the re-assertion and its suppression. Host-off presses are tried both tapped and held to tell the fixed stretch apart from the hand-over to the real button level, and a press with power refused shows the override. The power-on wait is tried with power allowed at once, allowed late with the button held (leading into the swallowed release) and never allowed (timeout). A phase with the tick stopped shows that only ticks, not clock cycles, end a phase.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;

   typedef enum logic [3:0] {
      PK_IDLE   = 4'd0,
      PK_T0     = 4'd1,
      PK_GAP    = 4'd2,
      PK_HELD   = 4'd3,
      PK_LID    = 4'd4,
      PK_EAT    = 4'd5,
      PK_INIT   = 4'd6,
      PK_BOOT   = 4'd7,
      PK_WASOFF = 4'd8
   } pk_state_e;

   function automatic int unsigned pk_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwrkey_timer.sv
// Single down-counter shared by all timed phases. A load sets the
// phase length in ticks; fire pulses on the tick that ends the phase.
module pwrkey_timer #(
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned RST_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             fire
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(RST_VAL);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_RST;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   assign fire = tick && (cnt_q == CNT_ONE);

endmodule

// File: rtl/pwrkey_initwatch.sv
// Counts ticks since reset and flags when the power-on wait must give up.
// LIMIT = 0 selects the variant with no timeout.
module pwrkey_initwatch #(
   parameter int unsigned LIMIT = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic expired
);

   generate
      if (LIMIT == 0) begin : g_none
         logic unused_in;
         assign unused_in = &{1'b0, clk, rst_n, tick};
         assign expired   = 1'b0;
      end else begin : g_cnt
         localparam int unsigned W = $clog2(LIMIT + 1);
         localparam logic [W-1:0] LIM = W'(LIMIT);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (tick && (cnt_q != LIM)) begin
               cnt_q <= cnt_q + W'(1);
            end
         end

         assign expired = (cnt_q == LIM);
      end
   endgenerate

endmodule

// File: rtl/pwrkey_cfg.sv
// Pulse-mode setting: written by cfg_wr, forced back on by host events.
module pwrkey_cfg (
   input  logic clk,
   input  logic rst_n,
   input  logic host_evt,
   input  logic cfg_wr,
   input  logic cfg_val,
   output logic pulse_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_en <= 1'b1;
      end else if (host_evt) begin
         pulse_en <= 1'b1;
      end else if (cfg_wr) begin
         pulse_en <= cfg_val;
      end
   end

endmodule

// File: rtl/pwrkey_stretch.sv
module pwrkey_stretch
   import pwrkey_pkg::*;
#(
   parameter int unsigned T0_MS           = 32,
   parameter int unsigned HOLD_MS         = 4000,
   parameter int unsigned STRETCH_MS      = 200,
   parameter int unsigned RECHECK_MS      = 100,
   parameter int unsigned INIT_TIMEOUT_MS = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_ms,
   input  logic btn_n,
   input  logic host_off,
   input  logic pwr_ok,
   input  logic lid_open_evt,
   input  logic host_evt,
   input  logic cfg_wr,
   input  logic cfg_pulse_en,
   output logic host_btn_n
);

   localparam int unsigned GAP_MS  = HOLD_MS - T0_MS;
   localparam int unsigned MAX_LEN = pk_max(pk_max(T0_MS, GAP_MS), pk_max(STRETCH_MS, RECHECK_MS));
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
   localparam logic [CNT_W-1:0] LD_T0      = CNT_W'(T0_MS);
   localparam logic [CNT_W-1:0] LD_GAP     = CNT_W'(GAP_MS);
   localparam logic [CNT_W-1:0] LD_STRETCH = CNT_W'(STRETCH_MS);
   localparam logic [CNT_W-1:0] LD_RECHECK = CNT_W'(RECHECK_MS);

   generate
      if (T0_MS < 1) begin : g_bad_t0
         $error("pwrkey_stretch: T0_MS must be at least 1");
      end
      if (HOLD_MS <= T0_MS) begin : g_bad_hold
         $error("pwrkey_stretch: HOLD_MS must exceed T0_MS");
      end
      if (STRETCH_MS < 1) begin : g_bad_stretch
         $error("pwrkey_stretch: STRETCH_MS must be at least 1");
      end
      if (RECHECK_MS < 1) begin : g_bad_recheck
         $error("pwrkey_stretch: RECHECK_MS must be at least 1");
      end
   endgenerate

   pk_state_e        state_q, state_d;
   logic             drv_q, drv_d;
   logic             btn_prev_n;
   logic             press_ev, rel_ev, btn_down;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_fire;
   logic             init_expired;
   logic             pulse_en;
   logic             lid_take;
   logic             power_block;

   pwrkey_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_ms),
      .load     (tmr_load),
      .load_val (tmr_val),
      .fire     (tmr_fire)
   );

   pwrkey_initwatch #(
      .LIMIT (INIT_TIMEOUT_MS)
   ) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_ms),
      .expired (init_expired)
   );

   pwrkey_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_evt (host_evt),
      .cfg_wr   (cfg_wr),
      .cfg_val  (cfg_pulse_en),
      .pulse_en (pulse_en)
   );

   // Button edge detection against last cycle's level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         btn_prev_n <= 1'b1;
      end else begin
         btn_prev_n <= btn_n;
      end
   end

   assign btn_down = ~btn_n;
   assign press_ev = btn_prev_n & ~btn_n;
   assign rel_ev   = ~btn_prev_n & btn_n;
   assign lid_take = lid_open_evt && host_off && (state_q != PK_INIT);

   always_comb begin
      state_d  = state_q;
      drv_d    = drv_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (lid_take) begin
         state_d  = PK_LID;
         drv_d    = 1'b1;
         tmr_load = 1'b1;
         tmr_val  = LD_STRETCH;
      end else begin
         unique case (state_q)
            PK_IDLE, PK_EAT: begin
               if (press_ev) begin
                  tmr_load = 1'b1;
                  if (host_off) begin
                     state_d = PK_WASOFF;
                     drv_d   = 1'b1;
                     tmr_val = LD_STRETCH;
                  end else if (pulse_en) begin
                     state_d = PK_T0;
                     drv_d   = 1'b1;
                     tmr_val = LD_T0;
                  end else begin
                     state_d = PK_GAP;
                     drv_d   = 1'b0;
                     tmr_val = LD_GAP;
                  end
               end else if (rel_ev) begin
                  state_d = PK_IDLE;
                  drv_d   = 1'b0;
               end
            end
            PK_T0: begin
               if (rel_ev) begin
                  state_d = PK_IDLE;
                  drv_d   = 1'b0;
               end else if (tmr_fire) begin
                  state_d  = PK_GAP;
                  drv_d    = 1'b0;
                  tmr_load = 1'b1;
                  tmr_val  = LD_GAP;
               end
            end
            PK_GAP: begin
               if (rel_ev) begin
                  state_d = PK_IDLE;
                  drv_d   = 1'b0;
               end else if (tmr_fire) begin
                  state_d = PK_HELD;
                  drv_d   = ~host_off;
               end
            end
            PK_HELD: begin
               if (rel_ev) begin
                  state_d = PK_IDLE;
                  drv_d   = 1'b0;
               end
            end
            PK_LID: begin
               if (tmr_fire) begin
                  state_d = PK_IDLE;
                  drv_d   = 1'b0;
               end
            end
            PK_WASOFF: begin
               if (tmr_fire) begin
                  if (btn_down) begin
                     state_d = PK_HELD;
                  end else begin
                     state_d = PK_IDLE;
                     drv_d   = 1'b0;
                  end
               end
            end
            PK_INIT: begin
               if (init_expired) begin
                  state_d = PK_IDLE;
                  drv_d   = 1'b0;
               end else if (tmr_fire) begin
                  tmr_load = 1'b1;
                  if (pwr_ok) begin
                     state_d = PK_BOOT;
                     drv_d   = 1'b1;
                     tmr_val = LD_STRETCH;
                  end else begin
                     tmr_val = LD_RECHECK;
                  end
               end
            end
            PK_BOOT: begin
               if (tmr_fire) begin
                  drv_d   = 1'b0;
                  state_d = btn_down ? PK_EAT : PK_IDLE;
               end
            end
            default: begin
               state_d = PK_IDLE;
               drv_d   = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PK_INIT;
         drv_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         drv_q   <= drv_d;
      end
   end

   // A low request never reaches an off host that may not power up.
   assign power_block = host_off & ~pwr_ok;
   assign host_btn_n  = ~(drv_q & ~power_block);

endmodule

// File: rtl/pwrkey_stretch_chk.sv
module pwrkey_stretch_chk
   import pwrkey_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input pk_state_e state,
   input logic      drv,
   input logic      press_ev,
   input logic      rel_ev,
   input logic      fire,
   input logic      lid_take,
   input logic      host_off,
   input logic      pwr_ok,
   input logic      pulse_en,
   input logic      host_evt,
   input logic      host_btn_n
);

   // R1: output released while reset is held
   p_reset_high_r1: assert property (@(posedge clk)
      !rst_n |=> host_btn_n);

   // R2: a press with the host on and pulse mode enabled starts the short pulse
   p_t0_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PK_IDLE && press_ev && !host_off && pulse_en && !lid_take)
      |=> (state == PK_T0 && drv));

   // R4: gap ending with the host off does not re-assert
   p_gap_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PK_GAP && fire && host_off && !lid_take)
      |=> (state == PK_HELD && !drv));

   // R5: a release in the reshaping phases returns to idle with the line high
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == PK_T0 || state == PK_GAP || state == PK_HELD) && rel_ev && !lid_take)
      |=> (state == PK_IDLE && !drv));

   // R7: no lid pulse out of the power-on wait
   p_lid_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PK_INIT) |=> (state != PK_LID));

   // R8: forced pulses run to their end regardless of the button
   p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == PK_LID || state == PK_WASOFF || state == PK_BOOT) && !fire && !lid_take)
      |=> ($stable(state) && drv));

   // R10: the swallowed-release state never requests low
   p_eat_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PK_EAT) |-> !drv);

   // R11: an off host without power permission never sees a press
   p_override_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_off && !pwr_ok) |-> host_btn_n);

   // R12: host events re-enable pulse mode
   p_cfg_reenable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      host_evt |=> pulse_en);

endmodule

bind pwrkey_stretch pwrkey_stretch_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .state      (state_q),
   .drv        (drv_q),
   .press_ev   (press_ev),
   .rel_ev     (rel_ev),
   .fire       (tmr_fire),
   .lid_take   (lid_take),
   .host_off   (host_off),
   .pwr_ok     (pwr_ok),
   .pulse_en   (pulse_en),
   .host_evt   (host_evt),
   .host_btn_n (host_btn_n)
);

// File: tb/tb_pwrkey_stretch.sv
`timescale 1ns/1ps
module tb_pwrkey_stretch;

   localparam int unsigned T0   = 4;
   localparam int unsigned HOLD = 20;
   localparam int unsigned GAP  = HOLD - T0;
   localparam int unsigned STR  = 8;
   localparam int unsigned RCK  = 3;
   localparam int unsigned TMO  = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_ms = 1'b1;
   logic btn_n = 1'b1;
   logic host_off = 1'b1;
   logic pwr_ok = 1'b1;
   logic lid_open_evt = 1'b0;
   logic host_evt = 1'b0;
   logic cfg_wr = 1'b0;
   logic cfg_pulse_en = 1'b1;
   logic host_btn_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pwrkey_stretch #(
      .T0_MS           (T0),
      .HOLD_MS         (HOLD),
      .STRETCH_MS      (STR),
      .RECHECK_MS      (RCK),
      .INIT_TIMEOUT_MS (TMO)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_ms      (tick_ms),
      .btn_n        (btn_n),
      .host_off     (host_off),
      .pwr_ok       (pwr_ok),
      .lid_open_evt (lid_open_evt),
      .host_evt     (host_evt),
      .cfg_wr       (cfg_wr),
      .cfg_pulse_en (cfg_pulse_en),
      .host_btn_n   (host_btn_n)
   );

   task automatic chk_bit(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: host_btn_n=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: length %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Count samples for which the output keeps level lvl, up to cap.
   task automatic run_len(input logic lvl, input int cap, output int n);
      n = 0;
      while (host_btn_n === lvl && n < cap) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic step(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic do_reset(input logic off, input logic ok);
      rst_n = 1'b0;
      btn_n = 1'b1;
      lid_open_evt = 1'b0;
      host_evt = 1'b0;
      cfg_wr = 1'b0;
      tick_ms = 1'b1;
      host_off = off;
      pwr_ok = ok;
      step(3);
      chk_bit("R1 reset level", host_btn_n, 1'b1);
      rst_n = 1'b1;
   endtask

   task automatic t_boot_now();
      int n;
      do_reset(1'b1, 1'b1);
      step(1);
      chk_bit("R1/R9 boot pulse starts", host_btn_n, 1'b0);
      run_len(1'b0, 100, n);
      chk_int("R9 boot pulse length", n, STR);
      step(3);
   endtask

   task automatic t_main_hold();
      int n;
      host_off = 1'b0;
      btn_n = 1'b0;
      step(1);
      chk_bit("R2 short pulse starts", host_btn_n, 1'b0);
      run_len(1'b0, 100, n);
      chk_int("R2 short pulse length", n, T0);
      run_len(1'b1, 100, n);
      chk_int("R2 gap length", n, GAP);
      step(5);
      chk_bit("R2 re-asserted while held", host_btn_n, 1'b0);
      btn_n = 1'b1;
      step(1);
      chk_bit("R5 release from held", host_btn_n, 1'b1);
      step(3);
   endtask

   task automatic t_release_in_t0();
      int n;
      btn_n = 1'b0;
      step(2);
      btn_n = 1'b1;
      step(1);
      chk_bit("R5 release in short pulse", host_btn_n, 1'b1);
      run_len(1'b1, 30, n);
      chk_int("R5 no later re-assertion", n, 30);
   endtask

   task automatic t_pulse_off();
      int n;
      cfg_wr = 1'b1;
      cfg_pulse_en = 1'b0;
      step(1);
      cfg_wr = 1'b0;
      btn_n = 1'b0;
      step(1);
      run_len(1'b1, 100, n);
      chk_int("R3 wait without pulse", n, GAP);
      chk_bit("R3 low after wait", host_btn_n, 1'b0);
      btn_n = 1'b1;
      step(1);
      chk_bit("R5 release after R3 hold", host_btn_n, 1'b1);
      step(3);
   endtask

   task automatic t_host_evt();
      int n;
      cfg_wr = 1'b1;
      cfg_pulse_en = 1'b0;
      host_evt = 1'b1;
      step(1);
      cfg_wr = 1'b0;
      host_evt = 1'b0;
      btn_n = 1'b0;
      step(1);
      chk_bit("R12 pulse re-enabled", host_btn_n, 1'b0);
      run_len(1'b0, 100, n);
      chk_int("R12 pulse length after host event", n, T0);
      btn_n = 1'b1;
      step(3);
   endtask

   task automatic t_gap_host_off();
      int n;
      host_off = 1'b0;
      pwr_ok = 1'b1;
      btn_n = 1'b0;
      step(1);
      run_len(1'b0, 100, n);
      chk_int("R2 pulse before gap", n, T0);
      host_off = 1'b1;
      run_len(1'b1, 60, n);
      chk_int("R4 no re-assert with host off", n, 60);
      btn_n = 1'b1;
      step(1);
      chk_bit("R4 high after release", host_btn_n, 1'b1);
      step(3);
   endtask

   task automatic t_off_tap();
      int n;
      host_off = 1'b1;
      pwr_ok = 1'b1;
      btn_n = 1'b0;
      step(1);
      chk_bit("R6 stretch starts", host_btn_n, 1'b0);
      step(1);
      btn_n = 1'b1;
      run_len(1'b0, 100, n);
      chk_int("R6/R8 stretch ignores release", n, STR - 1);
      step(5);
      chk_bit("R6 idle after tap", host_btn_n, 1'b1);
   endtask

   task automatic t_off_hold();
      int n;
      btn_n = 1'b0;
      step(1);
      run_len(1'b0, 30, n);
      chk_int("R6 held past stretch", n, 30);
      btn_n = 1'b1;
      step(1);
      chk_bit("R6 release after stretch", host_btn_n, 1'b1);
      step(3);
   endtask

   task automatic t_override();
      host_off = 1'b1;
      pwr_ok = 1'b0;
      btn_n = 1'b0;
      step(1);
      chk_bit("R11 press blocked", host_btn_n, 1'b1);
      step(2);
      chk_bit("R11 still blocked", host_btn_n, 1'b1);
      pwr_ok = 1'b1;
      step(1);
      chk_bit("R11 released once allowed", host_btn_n, 1'b0);
      step(10);
      btn_n = 1'b1;
      step(1);
      chk_bit("R6 release after override test", host_btn_n, 1'b1);
      step(3);
   endtask

   task automatic t_lid();
      int n;
      host_off = 1'b1;
      pwr_ok = 1'b1;
      lid_open_evt = 1'b1;
      step(1);
      lid_open_evt = 1'b0;
      chk_bit("R7 lid pulse starts", host_btn_n, 1'b0);
      step(1);
      btn_n = 1'b0;
      step(2);
      btn_n = 1'b1;
      run_len(1'b0, 100, n);
      chk_int("R7/R8 lid pulse ignores button", n, STR - 3);
      step(5);
      chk_bit("R8 no action after lid pulse", host_btn_n, 1'b1);
      host_off = 1'b0;
      lid_open_evt = 1'b1;
      step(1);
      lid_open_evt = 1'b0;
      run_len(1'b1, 10, n);
      chk_int("R7 lid ignored with host on", n, 10);
   endtask

   task automatic t_tick_freeze();
      int n;
      host_off = 1'b0;
      tick_ms = 1'b0;
      btn_n = 1'b0;
      step(20);
      chk_bit("R13 pulse frozen without ticks", host_btn_n, 1'b0);
      tick_ms = 1'b1;
      step(1);
      run_len(1'b0, 100, n);
      chk_int("R13 pulse resumes on ticks", n, T0 - 1);
      btn_n = 1'b1;
      step(3);
   endtask

   task automatic t_init_timeout();
      int n;
      do_reset(1'b1, 1'b0);
      step(5);
      btn_n = 1'b0;
      step(3);
      btn_n = 1'b1;
      step(TMO + 10);
      pwr_ok = 1'b1;
      run_len(1'b1, 10, n);
      chk_int("R9 gave up after timeout", n, 10);
      host_off = 1'b0;
      btn_n = 1'b0;
      step(1);
      run_len(1'b0, 100, n);
      chk_int("R9 idle after timeout", n, T0);
      btn_n = 1'b1;
      step(3);
   endtask

   task automatic t_late_power_eat();
      int n;
      int w;
      do_reset(1'b1, 1'b0);
      step(10);
      btn_n = 1'b0;
      pwr_ok = 1'b1;
      w = 0;
      while (host_btn_n === 1'b1 && w < 10) begin
         w++;
         @(negedge clk);
      end
      n_cmp++;
      if (w < 1 || w > RCK) begin
         n_bad++;
         $display("FAIL R9 recheck delay %0d expected 1..%0d", w, RCK);
      end
      run_len(1'b0, 100, n);
      chk_int("R9 late boot pulse length", n, STR);
      step(3);
      btn_n = 1'b1;
      run_len(1'b1, 10, n);
      chk_int("R10 release swallowed", n, 10);
      host_off = 1'b0;
      btn_n = 1'b0;
      step(1);
      run_len(1'b0, 100, n);
      chk_int("R10 next press normal", n, T0);
      btn_n = 1'b1;
      step(3);
   endtask

   initial begin
      t_boot_now();
      t_main_hold();
      t_release_in_t0();
      t_pulse_off();
      t_host_evt();
      t_gap_host_off();
      t_off_tap();
      t_off_hold();
      t_override();
      t_lid();
      t_tick_freeze();
      t_init_timeout();
      t_late_power_eat();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule